// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block turns CPU and picture-processor bus addresses into physical addresses inside the program ROM, the pattern (character) ROM and the work RAM of a banked cartridge. It receives four 5-bit configuration values from a separate loader: a control word, a low-half pattern bank, a high-half pattern bank and a program bank. It decodes them into a bank map that the address outputs follow directly. The translation is combinational, so an address presented on a cycle is translated on that same cycle.

On the program side, the 32 KiB window at 0x8000-0xFFFF is mapped in one of three ways. It can be one 32 KiB bank. It can be two 16 KiB halves with the lower half switchable and the upper half pinned to bank 15. It can be two 16 KiB halves with the lower half pinned to bank 0 and the upper half switchable. The block also gates access to the work RAM window at 0x6000-0x7FFF.

On the pattern side, the 8 KiB space is mapped as one 8 KiB bank or as two independent 4 KiB banks. The block reports the nametable mirroring mode and the nametable page (one of the two internal 1 KiB pages) for the current picture-processor address. When the program ROM is 512 KiB, bit 4 of a pattern-bank value becomes the top program bank bit. The only state in the block is a flag recording which pattern-bank value was committed last; the loader reports each commit with a one-cycle pulse.

Top module: `cart_bank_xlate`

## Requirements
- R1: `mirror_mode` equals control bits 1:0. `nt_page` is 0 for mode 0 (single page A) and 1 for mode 1 (single page B). For mode 2 (vertical) it equals `ppu_addr[10]`, and for mode 3 (horizontal) it equals `ppu_addr[11]`.
- R2: With control bit 3 clear (32 KiB program mode), the 16 KiB bank is {prg bank bits 3:1, `cpu_addr[14]`}. Program bank bit 0 has no effect.
- R3: With control bits 3 and 2 both set, addresses 0x8000-0xBFFF use program bank bits 3:0, and addresses 0xC000-0xFFFF use bank 15.
- R4: With control bit 3 set and bit 2 clear, addresses 0x8000-0xBFFF use bank 0, and addresses 0xC000-0xFFFF use program bank bits 3:0.
- R5: `prg_rom_addr` is bank × 16384 + `cpu_addr[13:0]`, and `prg_rom_cs` equals `cpu_addr[15]`.
- R6: `prg_ram_en` is 1 exactly when `cpu_addr[15:13]` is 3'b011 and program bank bit 4 is 0.
- R7: With control bit 4 clear (8 KiB pattern mode), the 4 KiB bank is {low-half bank bits 4:1, `ppu_addr[12]`}. The high-half value has no effect.
- R8: With control bit 4 set (4 KiB pattern mode), the 4 KiB bank is the low-half value when `ppu_addr[12]` is 0 and the high-half value when it is 1. `chr_addr` is bank × 4096 + `ppu_addr[11:0]`.
- R9: When `PRG_ROM_KB` is 512, bit 4 of the source value is ORed into program bank bit 4. The source value is the high-half value when control bit 4 is set and the last commit was to the high half; otherwise it is the low-half value. A high-half commit wins when both commit pulses are high in the same cycle.
- R10: Program and pattern bank numbers wrap modulo the number of banks present, which is `PRG_ROM_KB`/16 and `CHR_ROM_KB`/4 respectively.
- R11: After reset, the page-select source of R9 is the low-half value until a high-half commit occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl | input | 5 | Control word: bit 4 pattern mode, bit 3 program mode, bit 2 fixed-half choice, bits 1:0 mirroring |
| cfg_chr_lo | input | 5 | Low-half pattern bank value |
| cfg_chr_hi | input | 5 | High-half pattern bank value |
| cfg_prg | input | 5 | Program bank in bits 3:0, RAM disable in bit 4 |
| chr_lo_commit | input | 1 | Pulse when the loader commits the low-half value |
| chr_hi_commit | input | 1 | Pulse when the loader commits the high-half value |
| cpu_addr | input | 16 | CPU bus address |
| ppu_addr | input | 14 | Picture-processor bus address |
| prg_rom_cs | output | 1 | Program ROM window selected |
| prg_rom_addr | output | PRG_AW | Physical program ROM byte address |
| prg_ram_en | output | 1 | Work RAM access allowed |
| chr_addr | output | CHR_AW | Physical pattern ROM byte address |
| nt_page | output | 1 | Internal nametable page for the current address |
| mirror_mode | output | 2 | Decoded mirroring mode |

## Verification
The assertions assume that the configuration inputs and addresses are held steady around each rising clock edge. They compare the combinational outputs only at that edge. The bench changes every input on the falling edge and leaves the inputs alone until after the following rising edge, so each assertion sees a settled translation. Commit pulses are driven for exactly one cycle. The bench's own model of the last-commit flag updates on the same rising edge as the flag inside the design.

// File: rtl/cbx_pkg.sv
// Package: shared types for the cartridge bank translator.
// Assumes the control word bit order is fixed by the loader:
// bit 4 pattern mode, bit 3 program mode, bit 2 fixed-half, bits 1:0 mirroring.
package cbx_pkg;

    typedef enum logic [1:0] {
        MIR_ONE_A = 2'd0,
        MIR_ONE_B = 2'd1,
        MIR_VERT  = 2'd2,
        MIR_HORZ  = 2'd3
    } mirror_e;

    typedef struct packed {
        logic    chr_4k;
        logic    prg_16k;
        logic    fix_last;
        mirror_e mirror;
    } ctrl_t;

    localparam int CFG_W       = 5;
    localparam int PRG_OFS_W   = 14;
    localparam int CHR_OFS_W   = 12;
    localparam int LAST_BANK16 = 15;

endpackage

// File: rtl/cbx_chr_track.sv
// Module: records which pattern-bank value the loader committed last.
// Assumes each commit pulse lasts one cycle; a high-half commit wins a tie.
module cbx_chr_track (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_commit,
    input  logic hi_commit,
    output logic last_hi
);

    // Update the last-commit flag; reset points at the low half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_hi <= 1'b0;
        end else if (hi_commit) begin
            last_hi <= 1'b1;
        end else if (lo_commit) begin
            last_hi <= 1'b0;
        end
    end

endmodule

// File: rtl/cbx_prg_map.sv
// Module: maps the CPU program window onto 16 KiB ROM banks and gates work RAM.
// Assumes PRG_ROM_KB is a power of two between 32 and 512.
module cbx_prg_map
    import cbx_pkg::*;
#(
    parameter int PRG_ROM_KB = 256,
    localparam int PRG_BANKS  = PRG_ROM_KB / 16,
    localparam int PRG_BW     = $clog2(PRG_BANKS),
    localparam int PRG_AW     = PRG_BW + PRG_OFS_W
) (
    input  ctrl_t              ctrl,
    input  logic [CFG_W-1:0]   prg_sel,
    input  logic               page_bit,
    input  logic [15:0]        cpu_addr,
    output logic               rom_cs,
    output logic [PRG_AW-1:0]  rom_addr,
    output logic               ram_en
);

    logic [4:0] base_bank;
    logic [4:0] page_or;
    logic [4:0] full_bank;

    // Pick the 16 KiB bank before page select and wrapping.
    always_comb begin
        if (!ctrl.prg_16k) begin
            base_bank = {1'b0, prg_sel[3:1], cpu_addr[14]};
        end else if (ctrl.fix_last) begin
            base_bank = cpu_addr[14] ? 5'(LAST_BANK16) : {1'b0, prg_sel[3:0]};
        end else begin
            base_bank = cpu_addr[14] ? {1'b0, prg_sel[3:0]} : 5'd0;
        end
    end

    // The 256 KiB page bit exists only for the 512 KiB configuration.
    generate
        if (PRG_ROM_KB == 512) begin : g_page
            assign page_or = {page_bit, 4'b0000};
        end else begin : g_nopage
            assign page_or = 5'b00000;
        end
    endgenerate

    assign full_bank = base_bank | page_or;

    // Assemble the physical address; upper bank bits drop for wrapping.
    always_comb begin
        rom_addr = {full_bank[PRG_BW-1:0], cpu_addr[PRG_OFS_W-1:0]};
        rom_cs   = cpu_addr[15];
        ram_en   = (cpu_addr[15:13] == 3'b011) && !prg_sel[4];
    end

endmodule

// File: rtl/cbx_chr_map.sv
// Module: maps the 8 KiB pattern space onto 4 KiB ROM banks.
// Assumes CHR_ROM_KB is a power of two between 8 and 128.
module cbx_chr_map
    import cbx_pkg::*;
#(
    parameter int CHR_ROM_KB = 128,
    localparam int CHR_BANKS  = CHR_ROM_KB / 4,
    localparam int CHR_BW     = $clog2(CHR_BANKS),
    localparam int CHR_AW     = CHR_BW + CHR_OFS_W
) (
    input  logic               chr_4k,
    input  logic [CFG_W-1:0]   bank_lo,
    input  logic [CFG_W-1:0]   bank_hi,
    input  logic [12:0]        ppu_addr,
    output logic [CHR_AW-1:0]  chr_addr
);

    logic [4:0] bank4k;

    // Select the 4 KiB bank for the half being addressed.
    always_comb begin
        if (chr_4k) begin
            bank4k = ppu_addr[12] ? bank_hi : bank_lo;
        end else begin
            bank4k = {bank_lo[4:1], ppu_addr[12]};
        end
    end

    // Join bank and offset; upper bank bits drop for wrapping.
    assign chr_addr = {bank4k[CHR_BW-1:0], ppu_addr[CHR_OFS_W-1:0]};

endmodule

// File: rtl/cbx_nt_sel.sv
// Module: picks the internal nametable page from the mirroring mode.
// Assumes the address bits 11:10 identify the logical nametable.
module cbx_nt_sel
    import cbx_pkg::*;
(
    input  mirror_e     mode,
    input  logic [1:0]  nt_bits,
    output logic        page
);

    // Map the logical nametable to one of two physical pages.
    always_comb begin
        unique case (mode)
            MIR_ONE_A: page = 1'b0;
            MIR_ONE_B: page = 1'b1;
            MIR_VERT:  page = nt_bits[0];
            MIR_HORZ:  page = nt_bits[1];
            default:   page = 1'b0;
        endcase
    end

endmodule

// File: rtl/cart_bank_xlate.sv
// Module: top of the cartridge bank translator.
// Translates CPU and picture-processor addresses through the four
// configuration values; only the last-commit flag is stateful.
// Assumes configuration inputs change only between clock edges.
module cart_bank_xlate
    import cbx_pkg::*;
#(
    parameter int PRG_ROM_KB = 256,
    parameter int CHR_ROM_KB = 128,
    localparam int PRG_AW    = $clog2(PRG_ROM_KB / 16) + PRG_OFS_W,
    localparam int CHR_AW    = $clog2(CHR_ROM_KB / 4) + CHR_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        cfg_ctrl,
    input  logic [4:0]        cfg_chr_lo,
    input  logic [4:0]        cfg_chr_hi,
    input  logic [4:0]        cfg_prg,
    input  logic              chr_lo_commit,
    input  logic              chr_hi_commit,
    input  logic [15:0]       cpu_addr,
    input  logic [13:0]       ppu_addr,
    output logic              prg_rom_cs,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic              prg_ram_en,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              nt_page,
    output logic [1:0]        mirror_mode
);

    ctrl_t ctrl;
    logic  last_hi;
    logic  page_bit;

    assign ctrl        = ctrl_t'(cfg_ctrl);
    assign mirror_mode = ctrl.mirror;

    // Page-select source: high half only in 4 KiB mode after a high commit.
    assign page_bit = (ctrl.chr_4k && last_hi) ? cfg_chr_hi[4] : cfg_chr_lo[4];

    cbx_chr_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_commit (chr_lo_commit),
        .hi_commit (chr_hi_commit),
        .last_hi   (last_hi)
    );

    cbx_prg_map #(.PRG_ROM_KB(PRG_ROM_KB)) u_prg (
        .ctrl     (ctrl),
        .prg_sel  (cfg_prg),
        .page_bit (page_bit),
        .cpu_addr (cpu_addr),
        .rom_cs   (prg_rom_cs),
        .rom_addr (prg_rom_addr),
        .ram_en   (prg_ram_en)
    );

    cbx_chr_map #(.CHR_ROM_KB(CHR_ROM_KB)) u_chr (
        .chr_4k   (ctrl.chr_4k),
        .bank_lo  (cfg_chr_lo),
        .bank_hi  (cfg_chr_hi),
        .ppu_addr (ppu_addr[12:0]),
        .chr_addr (chr_addr)
    );

    cbx_nt_sel u_nt (
        .mode    (ctrl.mirror),
        .nt_bits (ppu_addr[11:10]),
        .page    (nt_page)
    );

endmodule

// File: rtl/cbx_checker.sv
// Module: protocol and mapping properties for cart_bank_xlate, attached by bind.
// Assumes inputs are stable at each rising edge.
module cbx_checker #(
    parameter int PRG_AW = 18,
    parameter int CHR_AW = 17,
    localparam int FIX_TOP = (PRG_AW - 14 < 4) ? PRG_AW - 1 : 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        cfg_ctrl,
    input logic [4:0]        cfg_prg,
    input logic [15:0]       cpu_addr,
    input logic [13:0]       ppu_addr,
    input logic [PRG_AW-1:0] prg_rom_addr,
    input logic              prg_ram_en,
    input logic [CHR_AW-1:0] chr_addr,
    input logic              nt_page
);

    assert_ram_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_prg[4] |-> !prg_ram_en);

    assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prg_rom_addr[13:0] == cpu_addr[13:0]);

    assert_fix_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ctrl[3] && cfg_ctrl[2] && cpu_addr[15:14] == 2'b11)
            |-> (&prg_rom_addr[FIX_TOP:14]));

    assert_fix_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ctrl[3] && !cfg_ctrl[2] && cpu_addr[15:14] == 2'b10)
            |-> (prg_rom_addr[FIX_TOP:14] == '0));

    assert_chr8_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ctrl[4] |-> (chr_addr[12] == ppu_addr[12]));

    assert_single_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ctrl[1] == 1'b0) |-> (nt_page == cfg_ctrl[0]));

endmodule

bind cart_bank_xlate cbx_checker #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ctrl     (cfg_ctrl),
    .cfg_prg      (cfg_prg),
    .cpu_addr     (cpu_addr),
    .ppu_addr     (ppu_addr),
    .prg_rom_addr (prg_rom_addr),
    .prg_ram_en   (prg_ram_en),
    .chr_addr     (chr_addr),
    .nt_page      (nt_page)
);

// File: tb/cart_bank_xlate_tb.sv
module cart_bank_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_ctrl = '0, cfg_chr_lo = '0, cfg_chr_hi = '0, cfg_prg = '0;
    logic        chr_lo_commit = 1'b0, chr_hi_commit = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [13:0] ppu_addr = '0;

    logic        cs_a, ram_a, nt_a, cs_b, ram_b, nt_b;
    logic [18:0] prg_a;
    logic [16:0] chr_a;
    logic [16:0] prg_b;
    logic [14:0] chr_b;
    logic [1:0]  mir_a, mir_b;

    int  n_run = 0;
    int  n_fail = 0;
    bit  last_hi_m = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    cart_bank_xlate #(.PRG_ROM_KB(512), .CHR_ROM_KB(128)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_chr_lo(cfg_chr_lo),
        .cfg_chr_hi(cfg_chr_hi), .cfg_prg(cfg_prg), .chr_lo_commit(chr_lo_commit),
        .chr_hi_commit(chr_hi_commit), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
        .prg_rom_cs(cs_a), .prg_rom_addr(prg_a), .prg_ram_en(ram_a),
        .chr_addr(chr_a), .nt_page(nt_a), .mirror_mode(mir_a));

    cart_bank_xlate #(.PRG_ROM_KB(128), .CHR_ROM_KB(32)) u_small (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_chr_lo(cfg_chr_lo),
        .cfg_chr_hi(cfg_chr_hi), .cfg_prg(cfg_prg), .chr_lo_commit(chr_lo_commit),
        .chr_hi_commit(chr_hi_commit), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
        .prg_rom_cs(cs_b), .prg_rom_addr(prg_b), .prg_ram_en(ram_b),
        .chr_addr(chr_b), .nt_page(nt_b), .mirror_mode(mir_b));

    function automatic int exp_prg(int kb);
        bit [4:0] b;
        bit pg;
        pg = (cfg_ctrl[4] && last_hi_m) ? cfg_chr_hi[4] : cfg_chr_lo[4];
        if (!cfg_ctrl[3])      b = {1'b0, cfg_prg[3:1], cpu_addr[14]};
        else if (cfg_ctrl[2])  b = cpu_addr[14] ? 5'd15 : {1'b0, cfg_prg[3:0]};
        else                   b = cpu_addr[14] ? {1'b0, cfg_prg[3:0]} : 5'd0;
        if (kb == 512 && pg) b[4] = 1'b1;
        return (int'(b) % (kb / 16)) * 16384 + int'(cpu_addr[13:0]);
    endfunction

    function automatic int exp_chr(int kb);
        bit [4:0] b;
        if (cfg_ctrl[4]) b = ppu_addr[12] ? cfg_chr_hi : cfg_chr_lo;
        else             b = {cfg_chr_lo[4:1], ppu_addr[12]};
        return (int'(b) % (kb / 4)) * 4096 + int'(ppu_addr[11:0]);
    endfunction

    function automatic int exp_nt();
        case (cfg_ctrl[1:0])
            2'd0: return 0;
            2'd1: return 1;
            2'd2: return int'(ppu_addr[10]);
            default: return int'(ppu_addr[11]);
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One step: drive at the falling edge, let the flag flop update, check after the edge.
    task automatic step(input bit [4:0] c, input bit [4:0] lo, input bit [4:0] hi,
                        input bit [4:0] p, input bit clo, input bit chi,
                        input bit [15:0] ca, input bit [13:0] pa);
        string pr, cr;
        @(negedge clk);
        cfg_ctrl = c; cfg_chr_lo = lo; cfg_chr_hi = hi; cfg_prg = p;
        chr_lo_commit = clo; chr_hi_commit = chi; cpu_addr = ca; ppu_addr = pa;
        @(posedge clk);
        if (chi) last_hi_m = 1'b1;
        else if (clo) last_hi_m = 1'b0;
        #2;
        pr = !c[3] ? "R2" : (c[2] ? "R3" : "R4");
        cr = c[4] ? "R8" : "R7";
        chk(pr, int'(prg_a), exp_prg(512));
        chk("R10", int'(prg_b), exp_prg(128));
        chk(cr, int'(chr_a), exp_chr(128));
        chk("R10", int'(chr_b), exp_chr(32));
        chk("R5", int'(cs_a), int'(ca[15]));
        chk("R6", int'(ram_a), int'(ca[15:13] == 3'b011 && !p[4]));
        chk("R1", int'(nt_a), exp_nt());
        chk("R1", int'(mir_a), int'(c[1:0]));
        @(negedge clk);
        chr_lo_commit = 1'b0; chr_hi_commit = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: after reset the page bit comes from the low half even in 4 KiB mode.
        step(5'b11100, 5'h10, 5'h00, 5'h03, 0, 0, 16'h8123, 14'h0000);
        chk("R11", int'(prg_a[18]), 1);
        // R9: a high commit switches the source to the high half.
        step(5'b11100, 5'h10, 5'h00, 5'h03, 0, 1, 16'h8123, 14'h1000);
        chk("R9", int'(prg_a[18]), 0);
        // R9: in 8 KiB mode the low half is the source regardless of last commit.
        step(5'b01100, 5'h10, 5'h00, 5'h03, 0, 0, 16'hC000, 14'h0000);
        chk("R9", int'(prg_a[18]), 1);
        // R9: tie of both commits picks the high half.
        step(5'b11100, 5'h00, 5'h10, 5'h01, 1, 1, 16'hC456, 14'h0fff);
        chk("R9", int'(prg_a[18]), 1);
        // R3: fixed-last half wraps to bank 7 on the 128 KiB part (R10).
        step(5'b01100, 5'h00, 5'h00, 5'h05, 0, 0, 16'hFFFF, 14'h0000);
        chk("R10", int'(prg_b[16:14]), 7);
        // R4: fixed-first half is bank 0.
        step(5'b01000, 5'h00, 5'h00, 5'h0D, 0, 0, 16'h8000, 14'h0000);
        // R2: program bank bit 0 ignored in 32 KiB mode.
        step(5'b00010, 5'h00, 5'h00, 5'h07, 0, 0, 16'h8001, 14'h0400);
        chk("R2", int'(prg_a[17:14]), 6);
        // R6: RAM window edges and disable bit.
        step(5'b00011, 5'h00, 5'h00, 5'h10, 0, 0, 16'h6000, 14'h0800);
        step(5'b00011, 5'h00, 5'h00, 5'h00, 0, 0, 16'h7FFF, 14'h0800);
        step(5'b00011, 5'h00, 5'h00, 5'h00, 0, 0, 16'h5FFF, 14'h0800);
        // R7: high-half value has no effect in 8 KiB pattern mode.
        step(5'b00000, 5'h09, 5'h1F, 5'h00, 0, 0, 16'h8000, 14'h1abc);
        chk("R7", int'(chr_a[16:12]), 9);

        for (int i = 0; i < 3000; i++) begin
            step(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom),
                 ($urandom % 4) == 0, ($urandom % 4) == 0,
                 16'($urandom), 14'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule